// File: doc/BRIEF.md
# Twelve-Hour BCD Time-of-Day Counter

This block keeps the time of day in twelve-hour form with a half-day (AM/PM) flag. The time is held as BCD digit pairs for seconds, minutes and hours, with one further modulo-2 stage for the half-day. A prescaler divides the reference clock down to a single-cycle one-second enable. Every stage advances on that enable, and only when all stages below it are at their last value. The hour field runs 12, 01, 02 … 11 and then back to 12. The half-day flag flips at the step from 11 to 12.

A load strobe writes a complete preset time in a single cycle and restarts the prescaler. Digits that are not valid BCD, or that lie out of range, are pulled to the nearest legal value. A run enable can freeze the prescaler, which freezes the clock with it. The one-second enable is also brought out as a tick output, so that neighbouring logic such as a display scanner or an alarm comparator can use it.

Top module: `tod_clock12`

## Requirements
- R1: A synchronous reset, active high, sets the time to 12:00:00 with the half-day flag at 0 (AM), clears the prescaler and holds tick low.
- R2: While run_en is 1, tick is high for one cycle in every TICK_DIV cycles. Tick equals run_en AND (prescaler at TICK_DIV-1). Each tick advances the time by exactly one second at that clock edge. The first tick after a reset or a load comes TICK_DIV-1 enabled cycles later.
- R3: The seconds digits count 00 to 59 in BCD, tens in 0..5 and units in 0..9, and wrap from 59 to 00.
- R4: Minutes advance by one only on a tick where the seconds wrap from 59 to 00. Otherwise they hold their value. They count 00 to 59 in the same way as the seconds.
- R5: Hours advance only on a tick where both minutes and seconds wrap. The hour sequence is 12, 01, 02 … 09, 10, 11, 12, and hours are never 00 or above 12.
- R6: The half-day flag (0 = AM, 1 = PM) flips only when the time steps from 11:59:59 to 12:00:00. It changes otherwise only by reset or load.
- R7: When load is 1 on a clock edge, every field takes its preset value at that edge and the prescaler is cleared. Load takes priority over a coincident tick.
- R8: A preset minutes or seconds tens digit above 5 becomes 5, and a preset units digit above 9 becomes 9.
- R9: For a preset hour, a tens digit above 1 becomes 1 and a units digit above 9 becomes 9. After that, any value above 12 becomes 12 and 00 becomes 01.
- R10: While run_en is 0, the prescaler and all time fields hold their values and tick stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Lets the prescaler count |
| load | input | 1 | Preset strobe |
| ld_pm | input | 1 | Preset half-day flag (1 = PM) |
| ld_hr_tens | input | 4 | Preset hour tens digit |
| ld_hr_units | input | 4 | Preset hour units digit |
| ld_min_tens | input | 4 | Preset minute tens digit |
| ld_min_units | input | 4 | Preset minute units digit |
| ld_sec_tens | input | 4 | Preset second tens digit |
| ld_sec_units | input | 4 | Preset second units digit |
| hr_tens | output | 4 | Hour tens digit |
| hr_units | output | 4 | Hour units digit |
| min_tens | output | 4 | Minute tens digit |
| min_units | output | 4 | Minute units digit |
| sec_tens | output | 4 | Second tens digit |
| sec_units | output | 4 | Second units digit |
| pm | output | 1 | Half-day flag, 1 = PM |
| tick | output | 1 | One-second enable pulse |

## Verification
A prescaler that is off by one shows up as a tick one cycle early or late, and so as a shifted seconds digit at the very next second. A broken carry between stages stays hidden until the seconds or minutes wrap. It then shows as a minute or hour digit that moves too soon or not at all. For this reason the bench loads presets just below every hour boundary in both half-days, so that each such wrap is reached within a few seconds. A wrong clamp shows in the cycle right after the load. For that reason every 4-bit pair of preset digits is swept.

// File: rtl/tod12_pkg.sv
`timescale 1ns/1ps
package tod12_pkg;

    typedef logic [3:0] digit_t;

    typedef struct packed {
        digit_t tens;
        digit_t units;
    } bcd2_t;

    localparam digit_t DIG_MAX     = 4'd9;
    localparam digit_t MS_TENS_MAX = 4'd5;
    localparam digit_t HR_TENS_MAX = 4'd1;

    localparam bcd2_t HR_TOP   = '{tens: 4'd1, units: 4'd2};
    localparam bcd2_t HR_ELVN  = '{tens: 4'd1, units: 4'd1};
    localparam bcd2_t HR_FIRST = '{tens: 4'd0, units: 4'd1};

    function automatic digit_t clip(digit_t d, digit_t lim);
        return (d > lim) ? lim : d;
    endfunction

    function automatic bcd2_t clamp_ms(bcd2_t v);
        bcd2_t r;
        r.tens  = clip(v.tens, MS_TENS_MAX);
        r.units = clip(v.units, DIG_MAX);
        return r;
    endfunction

    function automatic bcd2_t clamp_hr(bcd2_t v);
        bcd2_t r;
        r.tens  = clip(v.tens, HR_TENS_MAX);
        r.units = clip(v.units, DIG_MAX);
        if (r.tens == 4'd1 && r.units > 4'd2)
            r.units = 4'd2;
        if (r.tens == 4'd0 && r.units == 4'd0)
            r.units = 4'd1;
        return r;
    endfunction

    function automatic bcd2_t inc_ms(bcd2_t v);
        bcd2_t r;
        if (v.units == DIG_MAX) begin
            r.units = 4'd0;
            r.tens  = (v.tens == MS_TENS_MAX) ? 4'd0 : v.tens + 4'd1;
        end else begin
            r.units = v.units + 4'd1;
            r.tens  = v.tens;
        end
        return r;
    endfunction

    function automatic bcd2_t inc_hr(bcd2_t v);
        bcd2_t r;
        if (v == HR_TOP)
            r = HR_FIRST;
        else if (v.units == DIG_MAX)
            r = '{tens: 4'd1, units: 4'd0};
        else
            r = '{tens: v.tens, units: v.units + 4'd1};
        return r;
    endfunction

    function automatic logic hr_legal(bcd2_t v);
        if (v.tens == 4'd0)
            return (v.units >= 4'd1) && (v.units <= DIG_MAX);
        else if (v.tens == 4'd1)
            return v.units <= 4'd2;
        else
            return 1'b0;
    endfunction

endpackage

// File: rtl/tod_prescaler.sv
`timescale 1ns/1ps
module tod_prescaler #(
    parameter int unsigned TICK_DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run_en,
    output logic tick
);
    localparam int unsigned W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

    logic [W-1:0] cnt;

    assign tick = run_en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (run_en)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    a_r2_wrap_after_tick: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> (cnt == '0));

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !clr) |=> $stable(cnt));

endmodule

// File: rtl/tod_bcd60.sv
`timescale 1ns/1ps
module tod_bcd60
    import tod12_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld,
    input  logic  step,
    input  bcd2_t ld_val,
    output bcd2_t q,
    output logic  wrap
);
    assign wrap = step && (q.tens == MS_TENS_MAX) && (q.units == DIG_MAX);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= clamp_ms(ld_val);
        else if (step)
            q <= inc_ms(q);
    end

    a_r3_digit_range: assert property (@(posedge clk) disable iff (rst)
        (q.tens <= MS_TENS_MAX) && (q.units <= DIG_MAX));

    a_r4_hold_without_step: assert property (@(posedge clk) disable iff (rst)
        (!ld && !step) |=> $stable(q));

endmodule

// File: rtl/tod_hour12.sv
`timescale 1ns/1ps
module tod_hour12
    import tod12_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld,
    input  logic  step,
    input  bcd2_t ld_val,
    output bcd2_t q,
    output logic  to_noon
);
    assign to_noon = step && (q == HR_ELVN);

    always_ff @(posedge clk) begin
        if (rst)
            q <= HR_TOP;
        else if (ld)
            q <= clamp_hr(ld_val);
        else if (step)
            q <= inc_hr(q);
    end

    a_r5_hour_legal: assert property (@(posedge clk) disable iff (rst)
        hr_legal(q));

    a_r5_hold_without_step: assert property (@(posedge clk) disable iff (rst)
        (!ld && !step) |=> $stable(q));

endmodule

// File: rtl/tod_clock12.sv
`timescale 1ns/1ps
module tod_clock12
    import tod12_pkg::*;
#(
    parameter int unsigned TICK_DIV = 50_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en,
    input  logic       load,
    input  logic       ld_pm,
    input  logic [3:0] ld_hr_tens,
    input  logic [3:0] ld_hr_units,
    input  logic [3:0] ld_min_tens,
    input  logic [3:0] ld_min_units,
    input  logic [3:0] ld_sec_tens,
    input  logic [3:0] ld_sec_units,
    output logic [3:0] hr_tens,
    output logic [3:0] hr_units,
    output logic [3:0] min_tens,
    output logic [3:0] min_units,
    output logic [3:0] sec_tens,
    output logic [3:0] sec_units,
    output logic       pm,
    output logic       tick
);
    localparam int unsigned N_MS = 2;

    logic  sec_tick;
    bcd2_t ms_q    [N_MS];
    bcd2_t ms_ld   [N_MS];
    logic  ms_step [N_MS];
    logic  ms_wrap [N_MS];
    bcd2_t hr_q;
    logic  hr_noon;
    logic  pm_q;

    tod_prescaler #(.TICK_DIV(TICK_DIV)) i_presc (
        .clk    (clk),
        .rst    (rst),
        .clr    (load),
        .run_en (run_en),
        .tick   (sec_tick)
    );

    assign ms_ld[0] = '{tens: ld_sec_tens, units: ld_sec_units};
    assign ms_ld[1] = '{tens: ld_min_tens, units: ld_min_units};

    // stage 0 = seconds, stage 1 = minutes; each steps on the wrap of the one below
    for (genvar g = 0; g < N_MS; g++) begin : g_ms
        if (g == 0) begin : g_first
            assign ms_step[g] = sec_tick;
        end else begin : g_chain
            assign ms_step[g] = ms_wrap[g-1];
        end
        tod_bcd60 i_stage (
            .clk    (clk),
            .rst    (rst),
            .ld     (load),
            .step   (ms_step[g]),
            .ld_val (ms_ld[g]),
            .q      (ms_q[g]),
            .wrap   (ms_wrap[g])
        );
    end

    tod_hour12 i_hour (
        .clk     (clk),
        .rst     (rst),
        .ld      (load),
        .step    (ms_wrap[N_MS-1]),
        .ld_val  ('{tens: ld_hr_tens, units: ld_hr_units}),
        .q       (hr_q),
        .to_noon (hr_noon)
    );

    // modulo-2 half-day stage
    always_ff @(posedge clk) begin
        if (rst)
            pm_q <= 1'b0;
        else if (load)
            pm_q <= ld_pm;
        else if (hr_noon)
            pm_q <= ~pm_q;
    end

    assign sec_tens  = ms_q[0].tens;
    assign sec_units = ms_q[0].units;
    assign min_tens  = ms_q[1].tens;
    assign min_units = ms_q[1].units;
    assign hr_tens   = hr_q.tens;
    assign hr_units  = hr_q.units;
    assign pm        = pm_q;
    assign tick      = sec_tick;

    a_r1_reset_value: assert property (@(posedge clk)
        rst |=> (hr_tens == 4'd1 && hr_units == 4'd2 && min_tens == 4'd0 &&
                 min_units == 4'd0 && sec_tens == 4'd0 && sec_units == 4'd0 && !pm));

    a_r6_pm_flip_only_at_noon: assert property (@(posedge clk) disable iff (rst)
        (!load && !hr_noon) |=> $stable(pm_q));

    a_r6_noon_lands_on_twelve: assert property (@(posedge clk) disable iff (rst)
        (hr_noon && !load) |=> (hr_tens == 4'd1 && hr_units == 4'd2 && pm_q != $past(pm_q)));

endmodule

// File: tb/test_tod_clock12.sv
`timescale 1ns/1ps
module test_tod_clock12;

    localparam int DIV  = 4;
    localparam int HALF = 43200;
    localparam int DAY  = 86400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b1;
    logic load = 1'b0;
    logic ld_pm = 1'b0;
    logic [3:0] ld_hr_tens = '0, ld_hr_units = '0;
    logic [3:0] ld_min_tens = '0, ld_min_units = '0;
    logic [3:0] ld_sec_tens = '0, ld_sec_units = '0;
    logic [3:0] hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units;
    logic pm, tick;

    int total = 0;
    int bad = 0;
    int s_mod = 0;   // model: seconds since 12:00:00 AM
    int pc_mod = 0;  // model: prescaler count

    always #5 clk = ~clk;

    tod_clock12 #(.TICK_DIV(DIV)) i_tod_clock12 (
        .clk(clk), .rst(rst), .run_en(run_en), .load(load), .ld_pm(ld_pm),
        .ld_hr_tens(ld_hr_tens), .ld_hr_units(ld_hr_units),
        .ld_min_tens(ld_min_tens), .ld_min_units(ld_min_units),
        .ld_sec_tens(ld_sec_tens), .ld_sec_units(ld_sec_units),
        .hr_tens(hr_tens), .hr_units(hr_units),
        .min_tens(min_tens), .min_units(min_units),
        .sec_tens(sec_tens), .sec_units(sec_units),
        .pm(pm), .tick(tick)
    );

    function automatic int mini(int a, int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int preset_seconds();
        int ht, hu, hv, mv, sv;
        ht = mini(int'(ld_hr_tens), 1);
        hu = mini(int'(ld_hr_units), 9);
        hv = ht * 10 + hu;
        if (hv > 12) hv = 12;
        if (hv == 0) hv = 1;
        mv = mini(int'(ld_min_tens), 5) * 10 + mini(int'(ld_min_units), 9);
        sv = mini(int'(ld_sec_tens), 5) * 10 + mini(int'(ld_sec_units), 9);
        return (ld_pm ? HALF : 0) + (hv % 12) * 3600 + mv * 60 + sv;
    endfunction

    task automatic cyc();
        @(posedge clk);
        if (rst) begin
            s_mod = 0; pc_mod = 0;
        end else if (load) begin
            s_mod = preset_seconds(); pc_mod = 0;
        end else if (run_en) begin
            if (pc_mod == DIV - 1) begin
                pc_mod = 0;
                s_mod = (s_mod + 1) % DAY;
            end else begin
                pc_mod++;
            end
        end
        #1;
    endtask

    task automatic check(string tag);
        int r, h, m, sc;
        logic [24:0] exp_v, got_v;
        r  = s_mod % HALF;
        h  = r / 3600;
        if (h == 0) h = 12;
        m  = (r / 60) % 60;
        sc = r % 60;
        exp_v = {1'(s_mod >= HALF), 4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10),
                 4'(sc / 10), 4'(sc % 10)};
        got_v = {pm, hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units};
        total++;
        if (got_v !== exp_v || tick !== 1'(run_en && pc_mod == DIV - 1)) begin
            bad++;
            $display("FAIL %s: got %0d%0d:%0d%0d:%0d%0d pm=%0d tick=%0d exp %0d%0d:%0d%0d:%0d%0d pm=%0d tick=%0d",
                     tag, hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units, pm, tick,
                     exp_v[23:20], exp_v[19:16], exp_v[15:12], exp_v[11:8], exp_v[7:4], exp_v[3:0],
                     exp_v[24], run_en && pc_mod == DIV - 1);
        end
    endtask

    task automatic preset(int ht, int hu, int mt, int mu, int st, int su, logic p);
        ld_hr_tens = 4'(ht); ld_hr_units = 4'(hu);
        ld_min_tens = 4'(mt); ld_min_units = 4'(mu);
        ld_sec_tens = 4'(st); ld_sec_units = 4'(su);
        ld_pm = p;
        load = 1'b1;
        cyc();
        load = 1'b0;
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: run did not complete, got hang exp finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        #1;
        cyc(); cyc();
        check("R1");
        rst = 1'b0;
        check("R1");

        // R2 R3 R4: one full hour from reset, every cycle
        for (int i = 0; i < 3600 * DIV + 2; i++) begin
            cyc();
            check("R2 R3 R4");
        end

        // R5 R6: every hour boundary in both half-days
        for (int p = 0; p < 2; p++) begin
            for (int h = 1; h <= 12; h++) begin
                preset(h / 10, h % 10, 5, 9, 5, 8, 1'(p));
                check("R7");
                for (int k = 0; k < 3 * DIV; k++) begin
                    cyc();
                    check("R5 R6");
                end
            end
        end

        // R7: load in the middle of a prescaler period restarts it
        for (int k = 0; k < 2; k++) begin cyc(); check("R2"); end
        run_en = 1'b1;
        preset(1, 1, 5, 9, 5, 9, 1'b1);
        check("R7");
        for (int k = 0; k < 2 * DIV; k++) begin cyc(); check("R7 R6"); end

        // R8 R9: sweep all digit pairs, frozen so the load is seen alone
        run_en = 1'b0;
        for (int t = 0; t < 16; t++) begin
            for (int u = 0; u < 16; u++) begin
                preset(t, u, t, u, t, u, 1'(t));
                check("R8 R9");
            end
        end

        // R10: frozen clock holds
        for (int k = 0; k < 20; k++) begin cyc(); check("R10"); end
        run_en = 1'b1;
        for (int k = 0; k < 3 * DIV; k++) begin cyc(); check("R10 R2"); end

        // R1: reset in mid run
        rst = 1'b1; cyc(); rst = 1'b0;
        check("R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule